// File: doc/BRIEF.md
# Arithmetic-logic unit with condition-code register

This block is the data path and status keeper of a small 8-bit processor core. Each cycle in which a valid operation is presented, it combines two 8-bit operands and a 16-bit index value according to a 5-bit operation code. It then registers the byte result, the index result and an 8-bit condition-code register.

Each class of operation writes only its own subset of the status flags. Additions write every arithmetic flag, including the half-carry. Subtraction and compare write all of them except half-carry. Logic, load and store write negative and zero, and clear overflow. Index increment and decrement write only zero. Transfers and index additions touch no flag at all. Two further operations set and clear the maskable interrupt mask, and a combinational output passes an interrupt request through only while that mask is clear.

Top module: `alu_ccr`

## Requirements
- R1: After reset, `result` and `idx_out` are 0 and `ccr` is 8'hD0. The flag bit positions are: bit 7 stop-disable S, bit 6 non-maskable mask X, bit 5 half-carry H, bit 4 maskable mask I, bit 3 negative N, bit 2 zero Z, bit 1 overflow V, bit 0 carry C. All outputs are registered, so an accepted operation appears one clock later.
- R2: ADD (code 1) computes a+b and ADC (code 2) computes a+b+C, into `result`. C takes the carry out of bit 7, H the carry out of bit 3, and V is two's-complement overflow. N is result bit 7 and Z is set when the result is zero. No other operation changes H.
- R3: SUB (code 3) writes a-b to `result`. C is set when b is greater than a, taken unsigned. V is set on two's-complement overflow, and N and Z follow the result.
- R4: CMP (code 4) updates C, V, N and Z exactly as SUB would, and leaves `result` unchanged.
- R5: AND, OR, XOR, LOAD and STORE (codes 5, 6, 7, 12 and 13) write a&b, a|b, a^b, a and a respectively. N and Z follow the result, V is cleared, and C is kept.
- R6: LSL (code 8) writes a shifted left with a 0 fill. LSR (code 9) writes a shifted right with a 0 fill. C receives the bit shifted out, N and Z follow the result, and V equals N xor the new C.
- R7: ROL (code 10) fills bit 0 from the old C, and ROR (code 11) fills bit 7 from the old C. C receives the bit shifted out, and N, Z and V follow as in R6.
- R8: INX (code 14) writes `idx_in`+1 and DEX (code 15) writes `idx_in`-1 to `idx_out`, modulo 2^16. Only Z changes, and it is set when the 16-bit result is zero.
- R9: TFR (code 0) writes a to `result`, and ABX (code 18) writes `idx_in` plus the zero-extended b to `idx_out`. Neither changes any flag.
- R10: SETI (code 16) sets I and CLRI (code 17) clears it. `irq_signal` equals `irq_req` while I is clear and is 0 while I is set.
- R11: With `op_valid` low, or with an unused code (19 to 31), `result`, `idx_out` and `ccr` keep their values.
- R12: No operation changes the X or S bits after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation accepted on this edge |
| op_code | input | 5 | Operation class code |
| opnd_a | input | 8 | First byte operand |
| opnd_b | input | 8 | Second byte operand |
| idx_in | input | 16 | Index value for index operations |
| irq_req | input | 1 | Maskable interrupt request |
| result | output | 8 | Registered byte result |
| idx_out | output | 16 | Registered index result |
| ccr | output | 8 | Condition-code register |
| irq_signal | output | 1 | Request passed to the core while unmasked |

## Verification
On every cycle the assertions check the following. Compare leaves the result untouched. Index operations change only Z, and Z tracks the 16-bit result. Logic and load operations clear V and keep C. Transfers and idle cycles leave the state stable, and H moves only on additions. The interrupt output is checked to be blocked after the mask is set. The numeric correctness of every flag, meaning carry, borrow, half-carry and overflow at the 0x7F, 0x80, 0xFF and 0x0F boundaries, is shown only by the bench. Its behavioural model is compared on every clock across directed corner cases and a long pseudo-random run, and the same holds for rotate fill from carry and the 16-bit wrap of index operations.

// File: rtl/alu_ccr_pkg.sv
package alu_ccr_pkg;

    typedef enum logic [4:0] {
        OP_TFR   = 5'd0,
        OP_ADD   = 5'd1,
        OP_ADC   = 5'd2,
        OP_SUB   = 5'd3,
        OP_CMP   = 5'd4,
        OP_AND   = 5'd5,
        OP_OR    = 5'd6,
        OP_XOR   = 5'd7,
        OP_LSL   = 5'd8,
        OP_LSR   = 5'd9,
        OP_ROL   = 5'd10,
        OP_ROR   = 5'd11,
        OP_LOAD  = 5'd12,
        OP_STORE = 5'd13,
        OP_INX   = 5'd14,
        OP_DEX   = 5'd15,
        OP_SETI  = 5'd16,
        OP_CLRI  = 5'd17,
        OP_ABX   = 5'd18
    } op_e;

    // condition-code layout, MSB first
    typedef struct packed {
        logic s;
        logic x;
        logic h;
        logic i;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    // which status flags an operation writes
    typedef struct packed {
        logic c;
        logic v;
        logic z;
        logic n;
        logic h;
    } flag_wr_t;

    // candidate values for the status flags
    typedef struct packed {
        logic c;
        logic v;
        logic z;
        logic n;
        logic h;
    } flag_val_t;

    localparam ccr_t CCR_RESET = '{s: 1'b1, x: 1'b1, h: 1'b0, i: 1'b1,
                                   n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

endpackage

// File: rtl/alu_byte_unit.sv
module alu_byte_unit
    import alu_ccr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              res_en,
    output flag_val_t         fval,
    output flag_wr_t          fwr
);
    localparam int HALF_W = DATA_W / 2;
    localparam int MSB    = DATA_W - 1;

    logic [DATA_W:0]   sum_w;
    logic [HALF_W:0]   half_w;
    logic [DATA_W:0]   diff_w;
    logic              add_cin;
    logic              shl_fill;
    logic              shr_fill;
    logic [DATA_W-1:0] r_d;

    always_comb begin
        add_cin  = (op == OP_ADC) ? cin : 1'b0;
        sum_w    = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, add_cin};
        half_w   = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]}
                 + {{HALF_W{1'b0}}, add_cin};
        diff_w   = {1'b0, a} - {1'b0, b};
        shl_fill = (op == OP_ROL) ? cin : 1'b0;
        shr_fill = (op == OP_ROR) ? cin : 1'b0;
    end

    always_comb begin
        r_d    = a;
        res_en = 1'b0;
        fval   = '0;
        fwr    = '0;
        unique case (op)
            OP_TFR: begin
                r_d    = a;
                res_en = 1'b1;
            end
            OP_ADD, OP_ADC: begin
                r_d    = sum_w[DATA_W-1:0];
                res_en = 1'b1;
                fval.c = sum_w[DATA_W];
                fval.h = half_w[HALF_W];
                fval.v = (a[MSB] == b[MSB]) && (r_d[MSB] != a[MSB]);
                fwr    = '{c: 1'b1, v: 1'b1, z: 1'b1, n: 1'b1, h: 1'b1};
            end
            OP_SUB, OP_CMP: begin
                r_d    = diff_w[DATA_W-1:0];
                res_en = (op == OP_SUB);
                fval.c = diff_w[DATA_W];
                fval.v = (a[MSB] != b[MSB]) && (r_d[MSB] != a[MSB]);
                fwr    = '{c: 1'b1, v: 1'b1, z: 1'b1, n: 1'b1, h: 1'b0};
            end
            OP_AND, OP_OR, OP_XOR, OP_LOAD, OP_STORE: begin
                case (op)
                    OP_AND:  r_d = a & b;
                    OP_OR:   r_d = a | b;
                    OP_XOR:  r_d = a ^ b;
                    default: r_d = a;
                endcase
                res_en = 1'b1;
                fval.v = 1'b0;
                fwr    = '{c: 1'b0, v: 1'b1, z: 1'b1, n: 1'b1, h: 1'b0};
            end
            OP_LSL, OP_ROL: begin
                r_d    = {a[MSB-1:0], shl_fill};
                res_en = 1'b1;
                fval.c = a[MSB];
                fval.v = r_d[MSB] ^ a[MSB];
                fwr    = '{c: 1'b1, v: 1'b1, z: 1'b1, n: 1'b1, h: 1'b0};
            end
            OP_LSR, OP_ROR: begin
                r_d    = {shr_fill, a[MSB:1]};
                res_en = 1'b1;
                fval.c = a[0];
                fval.v = r_d[MSB] ^ a[0];
                fwr    = '{c: 1'b1, v: 1'b1, z: 1'b1, n: 1'b1, h: 1'b0};
            end
            default: begin
                r_d    = a;
                res_en = 1'b0;
            end
        endcase
        fval.z = (r_d == '0);
        fval.n = r_d[MSB];
        res    = r_d;
    end

endmodule

// File: rtl/alu_index_unit.sv
module alu_index_unit
    import alu_ccr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 16
) (
    input  op_e              op,
    input  logic [IDX_W-1:0] idx_in,
    input  logic [DATA_W-1:0] b,
    output logic [IDX_W-1:0] idx_res,
    output logic             idx_en,
    output logic             z_val,
    output logic             z_wr
);
    localparam int EXT_W = IDX_W - DATA_W;

    logic [IDX_W-1:0] addend;

    always_comb begin
        addend  = '0;
        idx_en  = 1'b1;
        z_wr    = 1'b0;
        case (op)
            OP_INX: begin
                addend = {{(IDX_W-1){1'b0}}, 1'b1};
                z_wr   = 1'b1;
            end
            OP_DEX: begin
                addend = {IDX_W{1'b1}};
                z_wr   = 1'b1;
            end
            OP_ABX: begin
                addend = {{EXT_W{1'b0}}, b};
            end
            default: begin
                idx_en = 1'b0;
            end
        endcase
        idx_res = idx_in + addend;
        z_val   = (idx_res == '0);
    end

endmodule

// File: rtl/alu_ccr_reg.sv
module alu_ccr_reg
    import alu_ccr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  op_e               op,
    input  logic [DATA_W-1:0] b_res,
    input  logic              b_res_en,
    input  flag_val_t         fval,
    input  flag_wr_t          fwr,
    input  logic [IDX_W-1:0]  i_res,
    input  logic              i_en,
    input  logic              i_z_val,
    input  logic              i_z_wr,
    output logic [DATA_W-1:0] res_q,
    output logic [IDX_W-1:0]  idx_q,
    output ccr_t              ccr_q
);
    typedef struct packed {
        ccr_t              ccr;
        logic [DATA_W-1:0] res;
        logic [IDX_W-1:0]  idx;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (valid) begin
            if (b_res_en) st_d.res = b_res;
            if (fwr.c)    st_d.ccr.c = fval.c;
            if (fwr.v)    st_d.ccr.v = fval.v;
            if (fwr.z)    st_d.ccr.z = fval.z;
            if (fwr.n)    st_d.ccr.n = fval.n;
            if (fwr.h)    st_d.ccr.h = fval.h;
            if (i_en)     st_d.idx = i_res;
            if (i_z_wr)   st_d.ccr.z = i_z_val;
            if (op == OP_SETI) st_d.ccr.i = 1'b1;
            if (op == OP_CLRI) st_d.ccr.i = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ccr <= CCR_RESET;
            st_q.res <= '0;
            st_q.idx <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_q = st_q.res;
    assign idx_q = st_q.idx;
    assign ccr_q = st_q.ccr;

    // R4: compare discards its difference
    a_r4_cmp_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
        valid && op == OP_CMP |=> $stable(res_q));

    // R8: index step touches only Z, which tracks the 16-bit value
    a_r8_index_z_only: assert property (@(posedge clk) disable iff (!rst_n)
        valid && (op == OP_INX || op == OP_DEX) |=>
            (ccr_q.z == (idx_q == '0)) &&
            $stable({ccr_q.s, ccr_q.x, ccr_q.h, ccr_q.i, ccr_q.n, ccr_q.v, ccr_q.c}));

    // R5: logic/load/store clear V, keep C, Z follows result
    a_r5_logic_clears_v: assert property (@(posedge clk) disable iff (!rst_n)
        valid && (op == OP_AND || op == OP_OR || op == OP_XOR ||
                  op == OP_LOAD || op == OP_STORE) |=>
            !ccr_q.v && $stable(ccr_q.c) && (ccr_q.z == (res_q == '0)));

    // R9: transfer and index add leave all flags alone
    a_r9_transfer_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        valid && (op == OP_TFR || op == OP_ABX) |=> $stable(ccr_q));

    // R11: idle cycles hold everything
    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(ccr_q) && $stable(res_q) && $stable(idx_q));

    // R2: half-carry moves only on additions
    a_r2_h_add_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && (op == OP_ADD || op == OP_ADC)) |=> $stable(ccr_q.h));

endmodule

// File: rtl/alu_ccr.sv
module alu_ccr
    import alu_ccr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 16,
    parameter int OP_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic              irq_req,
    output logic [DATA_W-1:0] result,
    output logic [IDX_W-1:0]  idx_out,
    output logic [7:0]        ccr,
    output logic              irq_signal
);
    op_e               op;
    logic [DATA_W-1:0] b_res;
    logic              b_res_en;
    flag_val_t         fval;
    flag_wr_t          fwr;
    logic [IDX_W-1:0]  i_res;
    logic              i_en;
    logic              i_z_val;
    logic              i_z_wr;
    ccr_t              ccr_q;

    assign op = op_e'(op_code);

    alu_byte_unit #(.DATA_W(DATA_W)) u_byte (
        .op     (op),
        .a      (opnd_a),
        .b      (opnd_b),
        .cin    (ccr_q.c),
        .res    (b_res),
        .res_en (b_res_en),
        .fval   (fval),
        .fwr    (fwr)
    );

    alu_index_unit #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_index (
        .op      (op),
        .idx_in  (idx_in),
        .b       (opnd_b),
        .idx_res (i_res),
        .idx_en  (i_en),
        .z_val   (i_z_val),
        .z_wr    (i_z_wr)
    );

    alu_ccr_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (op_valid),
        .op       (op),
        .b_res    (b_res),
        .b_res_en (b_res_en),
        .fval     (fval),
        .fwr      (fwr),
        .i_res    (i_res),
        .i_en     (i_en),
        .i_z_val  (i_z_val),
        .i_z_wr   (i_z_wr),
        .res_q    (result),
        .idx_q    (idx_out),
        .ccr_q    (ccr_q)
    );

    assign ccr        = ccr_q;
    assign irq_signal = irq_req & ~ccr_q.i;

    // R10: after the mask is set no request reaches the core
    a_r10_irq_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op == OP_SETI |=> !irq_signal);

endmodule

// File: tb/alu_ccr_test.sv
module alu_ccr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [7:0]  opnd_a = '0;
    logic [7:0]  opnd_b = '0;
    logic [15:0] idx_in = '0;
    logic        irq_req = 1'b0;
    logic [7:0]  result;
    logic [15:0] idx_out;
    logic [7:0]  ccr;
    logic        irq_signal;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // behavioural model state
    int m_res, m_idx;
    bit m_s, m_x, m_h, m_i, m_n, m_z, m_v, m_c;

    always #2 clk = ~clk;

    alu_ccr uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .idx_in(idx_in), .irq_req(irq_req),
        .result(result), .idx_out(idx_out), .ccr(ccr), .irq_signal(irq_signal)
    );

    function automatic string tag_of(bit v, int op);
        if (!v || op > 18) return "R11";
        case (op)
            0, 18:          return "R9";
            1, 2:           return "R2";
            3:              return "R3";
            4:              return "R4";
            5, 6, 7, 12, 13: return "R5";
            8, 9:           return "R6";
            10, 11:         return "R7";
            14, 15:         return "R8";
            default:        return "R10";
        endcase
    endfunction

    task automatic model_reset();
        m_res = 0; m_idx = 0;
        m_s = 1; m_x = 1; m_i = 1;
        m_h = 0; m_n = 0; m_z = 0; m_v = 0; m_c = 0;
    endtask

    task automatic set_nz(int r);
        m_n = (r >= 128);
        m_z = (r == 0);
    endtask

    task automatic model_apply(bit v, int op, int a, int b, int idx);
        int r, s, cin;
        bit oc;
        if (!v) return;
        oc = m_c;
        case (op)
            0: m_res = a;
            1, 2: begin
                cin = (op == 2) ? int'(oc) : 0;
                s = a + b + cin;
                r = s % 256;
                m_h = ((a % 16) + (b % 16) + cin) > 15;
                m_c = s > 255;
                m_v = ((~(a ^ b)) & (a ^ r) & 128) != 0;
                set_nz(r);
                m_res = r;
            end
            3, 4: begin
                r = (a - b + 256) % 256;
                m_c = a < b;
                m_v = ((a ^ b) & (a ^ r) & 128) != 0;
                set_nz(r);
                if (op == 3) m_res = r;
            end
            5, 6, 7, 12, 13: begin
                if (op == 5) r = a & b;
                else if (op == 6) r = a | b;
                else if (op == 7) r = a ^ b;
                else r = a;
                m_v = 0;
                set_nz(r);
                m_res = r;
            end
            8, 10: begin
                r = (a * 2) % 256 + ((op == 10) ? int'(oc) : 0);
                m_c = a >= 128;
                set_nz(r);
                m_v = m_n ^ m_c;
                m_res = r;
            end
            9, 11: begin
                r = a / 2 + ((op == 11 && oc) ? 128 : 0);
                m_c = (a % 2) == 1;
                set_nz(r);
                m_v = m_n ^ m_c;
                m_res = r;
            end
            14: begin m_idx = (idx + 1) % 65536; m_z = (m_idx == 0); end
            15: begin m_idx = (idx + 65535) % 65536; m_z = (m_idx == 0); end
            16: m_i = 1;
            17: m_i = 0;
            18: m_idx = (idx + b) % 65536;
            default: ;
        endcase
    endtask

    task automatic compare(string tag);
        logic [7:0] e_ccr;
        logic       e_irq;
        e_ccr = {m_s, m_x, m_h, m_i, m_n, m_z, m_v, m_c};
        e_irq = irq_req & ~m_i;
        checks++;
        if (result !== 8'(m_res) || idx_out !== 16'(m_idx) ||
            ccr !== e_ccr || irq_signal !== e_irq) begin
            failures++;
            $display("FAIL %s: result=%h idx=%h ccr=%h irq=%b expected result=%h idx=%h ccr=%h irq=%b",
                     tag, result, idx_out, ccr, irq_signal,
                     8'(m_res), 16'(m_idx), e_ccr, e_irq);
        end
        // R12: X and S stay set
        checks++;
        if (ccr[7:6] !== 2'b11) begin
            failures++;
            $display("FAIL R12: ccr[7:6]=%b expected 11", ccr[7:6]);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, check at the next falling edge
    task automatic step(bit v, int op, int a, int b, int idx, bit irq);
        op_valid = v;
        op_code  = 5'(op);
        opnd_a   = 8'(a);
        opnd_b   = 8'(b);
        idx_in   = 16'(idx);
        irq_req  = irq;
        model_apply(v, op, a, b, idx);
        @(negedge clk);
        compare(tag_of(v, op));
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");
        // R2 additions
        step(1, 1, 8'h0F, 8'h01, 0, 0);
        step(1, 1, 8'h7F, 8'h01, 0, 0);
        step(1, 1, 8'hFF, 8'h01, 0, 0);
        step(1, 2, 8'h10, 8'h20, 0, 0);
        step(1, 1, 8'h80, 8'h80, 0, 0);
        // R3 subtraction
        step(1, 3, 8'h00, 8'h01, 0, 0);
        step(1, 3, 8'h80, 8'h01, 0, 0);
        step(1, 3, 8'h55, 8'h55, 0, 0);
        // R4 compare keeps the result
        step(1, 1, 8'h12, 8'h22, 0, 0);
        step(1, 4, 8'h33, 8'h33, 0, 0);
        step(1, 4, 8'h01, 8'h02, 0, 0);
        // R5 logic and load
        step(1, 1, 8'h7F, 8'h01, 0, 0);
        step(1, 5, 8'hF0, 8'h0F, 0, 0);
        step(1, 12, 8'h80, 8'h00, 0, 0);
        step(1, 6, 8'h00, 8'h00, 0, 0);
        step(1, 13, 8'h01, 8'h00, 0, 0);
        // R6 shifts
        step(1, 8, 8'h80, 0, 0, 0);
        step(1, 9, 8'h01, 0, 0, 0);
        step(1, 8, 8'h40, 0, 0, 0);
        // R7 rotates through carry
        step(1, 9, 8'h01, 0, 0, 0);
        step(1, 10, 8'h00, 0, 0, 0);
        step(1, 9, 8'h03, 0, 0, 0);
        step(1, 11, 8'h00, 0, 0, 0);
        // R8 index step, Z only
        step(1, 14, 0, 0, 16'hFFFF, 0);
        step(1, 15, 0, 0, 16'h0001, 0);
        step(1, 15, 0, 0, 16'h0000, 0);
        step(1, 14, 0, 0, 16'h00FF, 0);
        // R9 transfer and index add
        step(1, 0, 8'hA5, 8'h00, 0, 0);
        step(1, 18, 0, 8'hFF, 16'hFF01, 0);
        // R10 interrupt mask
        step(1, 0, 8'h00, 0, 0, 1);
        step(1, 17, 0, 0, 0, 1);
        step(1, 0, 8'h01, 0, 0, 1);
        step(1, 16, 0, 0, 0, 1);
        // R11 idle and unused code
        step(0, 1, 8'hFF, 8'hFF, 0, 0);
        step(1, 25, 8'hFF, 8'hFF, 16'h1234, 0);
        // pseudo-random mix
        for (int k = 0; k < 600; k++) begin
            int op, idx;
            op  = $urandom_range(0, 20);
            idx = ($urandom_range(0, 3) == 0) ? (($urandom_range(0, 1) == 1) ? 16'hFFFF : 1)
                                              : $urandom_range(0, 65535);
            step($urandom_range(0, 7) != 0, op, $urandom_range(0, 255),
                 $urandom_range(0, 255), idx, $urandom_range(0, 1) == 1);
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule